// File: doc/BRIEF.md
# External Bus Request and Grant Arbiter

This block lets an outside master borrow the processor's external memory bus. It watches an asynchronous bus request input together with the core's external-access activity, including wait-state cycles. It decides the cycle in which the processor lets go of the address bus, the data bus and the memory strobes, and in which it raises bus grant. While the bus is lent out, it tells the core whether to halt. In go mode the core keeps executing until an instruction needs the external bus, and only then does it stop.

The core reports three things every cycle: whether an external access is running (`acc_busy_i`), whether this is the final cycle of that access (`acc_last_i`), and whether the current instruction wants the external bus (`acc_need_i`). The grant is only issued once a running access has finished. It may therefore fall between two external accesses of one instruction. When the request is withdrawn, grant drops first and the pad drivers are switched back on one cycle later. This means the two masters never drive the bus together. Arbitration keeps running while the processor core is held in reset.

Top module: `bus_grant_arb`

## Requirements
- R1: After the block reset `arb_rst`, `grant_o` is 0, every bit of `pad_oe_o` is 1 (drivers on), and `stall_o` is 0.
- R2: `ext_req_i` passes through a two-stage synchronizer. With no access running, a request first seen at clock edge k makes `grant_o` rise at edge k+2, and not before.
- R3: In every cycle in which `grant_o` is 1, every bit of `pad_oe_o` is 0. The bits of `pad_oe_o` are the address bus, the data bus and the select/strobe group, and they always switch together.
- R4: With `go_mode_i` = 0, `stall_o` is 1 in every cycle in which `grant_o` is 1.
- R5: With `go_mode_i` = 1, `stall_o` is 0 while the bus is lent out and `acc_need_i` is 0. It is 1 in the same cycle that `acc_need_i` is 1.
- R6: A request that arrives while an access is running (`acc_busy_i` = 1) is not granted in any cycle that follows a non-final access cycle. The grant rises in the cycle after the cycle flagged by `acc_last_i`.
- R7: A pending further access of the same instruction (`acc_need_i` = 1) does not delay the grant past the end of the current access.
- R8: Two edges after a withdrawn request is synchronized, `grant_o` falls while `pad_oe_o` stays 0. In the next cycle all of `pad_oe_o` returns to 1, and `stall_o` is 0 from then on.
- R9: While `core_rst_i` = 1, `acc_busy_i` and `acc_last_i` are ignored, and a request is granted with the R2 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| arb_rst | input | 1 | Synchronous active-high reset of this block |
| core_rst_i | input | 1 | Processor core reset; masks the access flags |
| ext_req_i | input | 1 | Asynchronous bus request from the outside master, active high |
| go_mode_i | input | 1 | Keep executing after grant until the bus is needed |
| acc_busy_i | input | 1 | An external access (including wait states) runs this cycle |
| acc_last_i | input | 1 | This cycle is the final cycle of the running access |
| acc_need_i | input | 1 | The current instruction wants the external bus |
| grant_o | output | 1 | Bus grant to the outside master, active high |
| stall_o | output | 1 | Halt request to the core |
| pad_oe_o | output | OE_W | Driver enables: bit 0 address, bit 1 data, bit 2 selects and strobes |

## Verification
The request reaches the decision flop after two synchronizer edges. The grant and the driver disable therefore appear on the third edge after the request changes, and release follows the same count, with driver re-enable one edge later still. Stimulus is applied on the falling edge. Each check samples on a falling edge after a counted number of rising edges: one count before the expected change, to show that it has not come early, and one at the change. The stall output depends on go mode and on the need flag within the same cycle, so it is sampled one time unit after those inputs move.

// File: rtl/bga_pkg.sv
package bga_pkg;
  typedef enum logic [1:0] {
    ARB_OWN    = 2'd0,
    ARB_LENT   = 2'd1,
    ARB_RETURN = 2'd2
  } arb_state_e;
endpackage

// File: rtl/bga_sync.sv
module bga_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  localparam int LAST = STAGES - 1;
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[LAST];
endmodule

// File: rtl/bga_fsm.sv
module bga_fsm
  import bga_pkg::*;
#(
  parameter int OE_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_s,
  input  logic            bus_free,
  output logic            grant_q,
  output logic            away,
  output logic [OE_W-1:0] oe_q
);
  arb_state_e state_q, state_d;
  logic       oe_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ARB_OWN:    if (req_s && bus_free) state_d = ARB_LENT;
      ARB_LENT:   if (!req_s)            state_d = ARB_RETURN;
      ARB_RETURN:                        state_d = ARB_OWN;
      default:                           state_d = ARB_OWN;
    endcase
  end

  // drivers stay off through the return cycle, back on when owning again
  assign oe_d = (state_d == ARB_OWN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ARB_OWN;
      grant_q <= 1'b0;
    end else begin
      state_q <= state_d;
      grant_q <= (state_d == ARB_LENT);
    end
  end

  // one flop per driver group so each pad group has its own enable source
  genvar g;
  generate
    for (g = 0; g < OE_W; g++) begin : g_oe
      always_ff @(posedge clk) begin
        if (rst) oe_q[g] <= 1'b1;
        else     oe_q[g] <= oe_d;
      end
    end
  endgenerate

  assign away = (state_q != ARB_OWN);
endmodule

// File: rtl/bga_stall.sv
module bga_stall (
  input  logic away,
  input  logic go_mode,
  input  logic need,
  output logic stall
);
  assign stall = away & (~go_mode | need);
endmodule

// File: rtl/bus_grant_arb.sv
module bus_grant_arb #(
  parameter int SYNC_STAGES = 2,
  parameter int OE_W        = 3
) (
  input  logic            clk,
  input  logic            arb_rst,
  input  logic            core_rst_i,
  input  logic            ext_req_i,
  input  logic            go_mode_i,
  input  logic            acc_busy_i,
  input  logic            acc_last_i,
  input  logic            acc_need_i,
  output logic            grant_o,
  output logic            stall_o,
  output logic [OE_W-1:0] pad_oe_o
);
  logic req_s;
  logic bus_free;
  logic away;

  bga_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (arb_rst),
    .d   (ext_req_i),
    .q   (req_s)
  );

  // free when no access runs, the access ends now, or the core is in reset
  assign bus_free = core_rst_i | ~acc_busy_i | acc_last_i;

  bga_fsm #(.OE_W(OE_W)) u_fsm (
    .clk      (clk),
    .rst      (arb_rst),
    .req_s    (req_s),
    .bus_free (bus_free),
    .grant_q  (grant_o),
    .away     (away),
    .oe_q     (pad_oe_o)
  );

  bga_stall u_stall (
    .away    (away),
    .go_mode (go_mode_i),
    .need    (acc_need_i),
    .stall   (stall_o)
  );
endmodule

// File: rtl/bga_chk.sv
module bga_chk #(
  parameter int OE_W = 3
) (
  input logic            clk,
  input logic            arb_rst,
  input logic            core_rst_i,
  input logic            go_mode_i,
  input logic            acc_busy_i,
  input logic            acc_last_i,
  input logic            acc_need_i,
  input logic            grant_o,
  input logic            stall_o,
  input logic [OE_W-1:0] pad_oe_o
);
  p_drivers_off_r3: assert property (@(posedge clk) disable iff (arb_rst)
    grant_o |-> (pad_oe_o == '0));

  p_groups_together_r3: assert property (@(posedge clk) disable iff (arb_rst)
    (pad_oe_o == '0) || (pad_oe_o == {OE_W{1'b1}}));

  p_halt_r4: assert property (@(posedge clk) disable iff (arb_rst)
    (grant_o && !go_mode_i) |-> stall_o);

  p_go_need_r5: assert property (@(posedge clk) disable iff (arb_rst)
    (grant_o && acc_need_i) |-> stall_o);

  p_wait_access_r6: assert property (@(posedge clk) disable iff (arb_rst)
    (acc_busy_i && !acc_last_i && !core_rst_i && !grant_o) |=> !grant_o);

  p_gap_on_drop_r8: assert property (@(posedge clk) disable iff (arb_rst)
    $fell(grant_o) |-> (pad_oe_o == '0));

  p_reenable_r8: assert property (@(posedge clk) disable iff (arb_rst)
    $fell(grant_o) |=> (pad_oe_o == {OE_W{1'b1}}));
endmodule

bind bus_grant_arb bga_chk #(.OE_W(OE_W)) u_chk (
  .clk        (clk),
  .arb_rst    (arb_rst),
  .core_rst_i (core_rst_i),
  .go_mode_i  (go_mode_i),
  .acc_busy_i (acc_busy_i),
  .acc_last_i (acc_last_i),
  .acc_need_i (acc_need_i),
  .grant_o    (grant_o),
  .stall_o    (stall_o),
  .pad_oe_o   (pad_oe_o)
);

// File: tb/bus_grant_arb_test.sv
`timescale 1ns/1ps
module bus_grant_arb_test;
  localparam int OE_W = 3;
  localparam logic [OE_W-1:0] ON = {OE_W{1'b1}};

  logic clk = 1'b0;
  logic arb_rst, core_rst_i, ext_req_i, go_mode_i;
  logic acc_busy_i, acc_last_i, acc_need_i;
  logic grant_o, stall_o;
  logic [OE_W-1:0] pad_oe_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bus_grant_arb #(.SYNC_STAGES(2), .OE_W(OE_W)) uut (
    .clk(clk), .arb_rst(arb_rst), .core_rst_i(core_rst_i),
    .ext_req_i(ext_req_i), .go_mode_i(go_mode_i),
    .acc_busy_i(acc_busy_i), .acc_last_i(acc_last_i), .acc_need_i(acc_need_i),
    .grant_o(grant_o), .stall_o(stall_o), .pad_oe_o(pad_oe_o)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic release_bus(string tag, int ret_stall);
    ext_req_i = 1'b0;
    edges(2);
    check({tag, " grant held until synced"}, grant_o, 1);
    edges(1);
    check({tag, " grant dropped"}, grant_o, 0);
    check({tag, " drivers still off"}, pad_oe_o, 0);
    check({tag, " stall in return cycle"}, stall_o, ret_stall);
    edges(1);
    check({tag, " drivers back"}, pad_oe_o, ON);
    check({tag, " stall released"}, stall_o, 0);
  endtask

  task automatic t_reset;
    arb_rst = 1'b1; core_rst_i = 1'b0; ext_req_i = 1'b0; go_mode_i = 1'b0;
    acc_busy_i = 1'b0; acc_last_i = 1'b0; acc_need_i = 1'b0;
    edges(3);
    arb_rst = 1'b0;
    edges(1);
    check("R1 grant", grant_o, 0);
    check("R1 oe", pad_oe_o, ON);
    check("R1 stall", stall_o, 0);
  endtask

  task automatic t_idle_grant;
    ext_req_i = 1'b1;
    edges(2);
    check("R2 not early", grant_o, 0);
    edges(1);
    check("R2 grant", grant_o, 1);
    check("R3 drivers off", pad_oe_o, 0);
    check("R4 halted", stall_o, 1);
    edges(4);
    check("R4 still halted", stall_o, 1);
    release_bus("R8", 1);
  endtask

  task automatic t_access_wait;
    acc_busy_i = 1'b1; acc_last_i = 1'b0;
    ext_req_i = 1'b1;
    edges(7);
    check("R6 held off during wait states", grant_o, 0);
    check("R6 drivers on during access", pad_oe_o, ON);
    acc_last_i = 1'b1;
    edges(1);
    check("R6 grant after last cycle", grant_o, 1);
    acc_busy_i = 1'b0; acc_last_i = 1'b0;
    release_bus("R6 release", 1);
  endtask

  task automatic t_between;
    acc_need_i = 1'b1; acc_busy_i = 1'b1; acc_last_i = 1'b0;
    ext_req_i = 1'b1;
    edges(3);
    check("R7 held during first access", grant_o, 0);
    acc_last_i = 1'b1;
    edges(1);
    check("R7 grant between accesses", grant_o, 1);
    check("R7 core halted", stall_o, 1);
    acc_busy_i = 1'b0; acc_last_i = 1'b0;
    release_bus("R7 release", 1);
    acc_need_i = 1'b0;
  endtask

  task automatic t_go;
    go_mode_i = 1'b1;
    ext_req_i = 1'b1;
    edges(3);
    check("R5 grant", grant_o, 1);
    check("R5 keeps running", stall_o, 0);
    acc_need_i = 1'b1;
    #1;
    check("R5 halts on need", stall_o, 1);
    acc_need_i = 1'b0;
    #1;
    check("R5 runs again", stall_o, 0);
    @(negedge clk);
    release_bus("R5 release", 0);
    go_mode_i = 1'b0;
  endtask

  task automatic t_core_reset;
    core_rst_i = 1'b1; acc_busy_i = 1'b1; acc_last_i = 1'b0;
    ext_req_i = 1'b1;
    edges(2);
    check("R9 not early", grant_o, 0);
    edges(1);
    check("R9 grant in core reset", grant_o, 1);
    check("R9 drivers off", pad_oe_o, 0);
    acc_busy_i = 1'b0;
    release_bus("R9 release", 1);
    core_rst_i = 1'b0;
  endtask

  initial begin
    t_reset();
    t_idle_grant();
    t_access_wait();
    t_between();
    t_go();
    t_core_reset();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule